// File: doc/BRIEF.md
# Jittered PWM Switching Oscillator

This block sets the switching rhythm of a current-mode power converter controller. It runs from a fast system clock. It divides that clock down to a switching period near a nominal value, and it sweeps that period slowly up and down with a triangular profile. The sweep spreads the energy of each switching harmonic over a band of side frequencies. At the first clock of every period it raises a one-cycle strobe. From the following clock it opens a gate-on window for the power switch.

Four limits bound the gate window. A cap ends it at a fixed fraction of the current period. A minimum on time applies once a pulse has begun. A blanking interval at turn-on masks the current-sense comparator. The comparator itself, once it is unmasked, ends the pulse within the same clock. A burst-inhibit input stops a new pulse from starting. An enable input forces the gate low at once and freezes the sweep. A parameter selects the low-frequency variant or the high-frequency variant. The comparator, the sense transistor and the gate driver are outside the block; they appear as single-bit inputs and outputs.

Top module: `jit_pwm_osc`

## Requirements
- R1: While `rst_n` is low the gate is low. After release with enable low, both the gate and the strobe stay low.
- R2: With zero sweep offset, a period lasts floor(CLK_HZ / F_nom) clocks, where F_nom is 60 kHz in the low variant and 115 kHz in the high variant. At the default 10 MHz clock in the low variant this is 166 clocks.
- R3: The period length is the nominal count plus a signed offset. The offset starts at 0 after reset. It changes by one after every STEP complete periods, rising to +DEV, then falling to -DEV, then rising again. DEV = (floor(CLK_HZ/(F_nom-F_dev)) - floor(CLK_HZ/(F_nom+F_dev)))/2, where F_dev is 4 kHz in the low variant and 8 kHz in the high variant. STEP = floor((F_nom/250 Hz)/(4*DEV)). The defaults give DEV = 11 and STEP = 5.
- R4: The strobe is high for exactly the first clock of each period. When burst is low in that clock, the gate goes high in the next clock.
- R5: A pulse lasts at most floor(period*80/100) clocks. With no sense trip it lasts exactly that long.
- R6: Once a pulse has started, a sense trip cannot end it before ceil(400 ns * CLK_HZ) clocks of gate-high time, which is 4 at the defaults.
- R7: The sense input has no effect during the first ceil(300 ns * CLK_HZ) gate-high clocks, which is 3 at the defaults.
- R8: A sense trip in a gate-high clock past both guards drives the gate low in that same clock. The gate then stays low until the next period strobe.
- R9: If burst is high in a strobe clock, no pulse starts in that period. Period timing and the sweep continue unchanged.
- R10: When enable falls, the gate and strobe go low in that same clock, the period restarts, and the sweep state is held. The first clock with enable high again carries a strobe, and the sweep continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the gate off and freezes the sweep |
| burst_i | input | 1 | Burst inhibit; high in a strobe clock skips that pulse |
| cs_trip_i | input | 1 | Current-sense comparator output; high ends the pulse after the guards |
| period_start_o | output | 1 | One-clock strobe at the start of each switching period |
| gate_o | output | 1 | Gate-on window for the power switch |

## Verification
The bench builds the block with its defaults: a 10 MHz clock and the low variant. That gives a 166-clock nominal period, an 11-clock sweep depth and an offset step every 5 periods. About 260 periods at this size cover a whole triangle, both turning points and the wrap back through zero. The bench predicts every period length and every pulse width arithmetically from the sweep rules and the 80 percent cap. With guards of 3 and 4 clocks, sense pulses placed at on-clocks 2, 4 and 5 separate blanking, the minimum on time and a live trip. Enable gaps inserted mid-sweep show that the profile resumes at the same point.

// File: rtl/jit_pkg.sv
package jit_pkg;

   // Converts a duration in nanoseconds to whole clock cycles, rounding up.
   function automatic int ns_to_cyc(input longint ns, input longint clk_hz);
      longint num;
      num = ns * clk_hz + 64'sd999999999;
      return int'(num / 64'sd1000000000);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/jit_mod_profile.sv
module jit_mod_profile #(
   parameter int DEV  = 11,
   parameter int STEP = 5,
   parameter int OW   = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv_i,
   output logic signed [OW-1:0] offs_o
);

   generate
      if (DEV == 0) begin : g_flat
         assign offs_o = '0;
      end else begin : g_tri
         localparam int SW = (STEP > 1) ? $clog2(STEP) : 1;
         localparam logic signed [OW-1:0] TOP_M1 = OW'(DEV - 1);
         localparam logic signed [OW-1:0] BOT_P1 = OW'(1 - DEV);

         logic [SW-1:0]        div_q;
         logic                 up_q;
         logic signed [OW-1:0] offs_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               div_q  <= '0;
               up_q   <= 1'b1;
               offs_q <= '0;
            end else if (adv_i) begin
               if (div_q == SW'(STEP - 1)) begin
                  div_q <= '0;
                  if (up_q) begin
                     offs_q <= offs_q + OW'(1);
                     if (offs_q == TOP_M1) up_q <= 1'b0;
                  end else begin
                     offs_q <= offs_q - OW'(1);
                     if (offs_q == BOT_P1) up_q <= 1'b1;
                  end
               end else begin
                  div_q <= div_q + SW'(1);
               end
            end
         end

         assign offs_o = offs_q;
      end
   endgenerate

endmodule

// File: rtl/jit_period_timer.sv
module jit_period_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic [CW-1:0] len_i,
   output logic          start_o,
   output logic          end_o
);

   logic [CW-1:0] ph_q;
   logic          last;

   assign last    = (ph_q == len_i - CW'(1));
   assign start_o = en_i && (ph_q == '0);
   assign end_o   = en_i && last;

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) ph_q <= '0;
      else if (last)       ph_q <= '0;
      else                 ph_q <= ph_q + CW'(1);
   end

endmodule

// File: rtl/jit_pulse_gen.sv
module jit_pulse_gen #(
   parameter int CW    = 8,
   parameter int GUARD = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          start_i,
   input  logic          burst_i,
   input  logic          cs_i,
   input  logic [CW-1:0] cap_i,
   output logic          gate_o
);

   logic          on_q;
   logic [CW-1:0] ton_q;
   logic          trip;

   // ton_q holds the index of the current gate-high clock, counting from 1
   assign trip   = on_q && cs_i && (ton_q > CW'(GUARD));
   assign gate_o = en_i && on_q && !trip;

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         on_q  <= 1'b0;
         ton_q <= '0;
      end else if (start_i && !burst_i) begin
         on_q  <= 1'b1;
         ton_q <= CW'(1);
      end else if (on_q) begin
         if (trip || ton_q >= cap_i) on_q <= 1'b0;
         else                        ton_q <= ton_q + CW'(1);
      end
   end

endmodule

// File: rtl/jit_pwm_osc.sv
module jit_pwm_osc #(
   parameter int CLK_HZ       = 10_000_000,
   parameter bit HIGH_VARIANT = 1'b0,
   parameter int MOD_HZ       = 250,
   parameter int DUTY_PCT     = 80,
   parameter int MIN_ON_NS    = 400,
   parameter int LEB_NS       = 300
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic burst_i,
   input  logic cs_trip_i,
   output logic period_start_o,
   output logic gate_o
);

   localparam int F_NOM       = HIGH_VARIANT ? 115_000 : 60_000;
   localparam int F_DEV       = HIGH_VARIANT ? 8_000 : 4_000;
   localparam int NOM_CYC     = CLK_HZ / F_NOM;
   localparam int SLOW_CYC    = CLK_HZ / (F_NOM - F_DEV);
   localparam int FAST_CYC    = CLK_HZ / (F_NOM + F_DEV);
   localparam int DEV_CYC     = (SLOW_CYC - FAST_CYC) / 2;
   localparam int MOD_PERIODS = F_NOM / MOD_HZ;
   localparam int STEP_RAW    = (DEV_CYC == 0) ? 1 : MOD_PERIODS / (4 * DEV_CYC);
   localparam int STEP_PER    = (STEP_RAW < 1) ? 1 : STEP_RAW;
   localparam int PER_MAX     = NOM_CYC + DEV_CYC;
   localparam int PER_MIN     = NOM_CYC - DEV_CYC;
   localparam int CW          = $clog2(PER_MAX + 1);
   localparam int OW          = $clog2(DEV_CYC + 1) + 1;
   localparam int PW          = CW + 7;
   localparam int MIN_ON_CYC  = jit_pkg::ns_to_cyc(MIN_ON_NS, CLK_HZ);
   localparam int LEB_CYC     = jit_pkg::ns_to_cyc(LEB_NS, CLK_HZ);
   localparam int GUARD_CYC   = jit_pkg::max2(MIN_ON_CYC, LEB_CYC);
   localparam int ON_CAP_MIN  = PER_MIN * DUTY_PCT / 100;
   localparam int ON_CAP_MAX  = PER_MAX * DUTY_PCT / 100;

   // elaboration-time parameter checks
   if (DUTY_PCT < 1 || DUTY_PCT > 99) begin : g_bad_duty
      $error("jit_pwm_osc: DUTY_PCT must lie in 1..99");
   end
   if (MOD_HZ < 1) begin : g_bad_mod
      $error("jit_pwm_osc: MOD_HZ must be positive");
   end
   if (PER_MIN < 4) begin : g_bad_clk
      $error("jit_pwm_osc: CLK_HZ too low for the selected variant");
   end
   if (ON_CAP_MIN <= GUARD_CYC) begin : g_bad_guard
      $error("jit_pwm_osc: duty cap shorter than the turn-on guard");
   end

   logic signed [OW-1:0] offs;
   logic [CW-1:0]        per_len;
   logic [CW-1:0]        on_cap;
   logic [PW-1:0]        prod;
   logic                 per_end;
   logic                 per_start;

   jit_mod_profile #(
      .DEV  (DEV_CYC),
      .STEP (STEP_PER),
      .OW   (OW)
   ) u_prof (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (per_end),
      .offs_o (offs)
   );

   assign per_len = CW'(NOM_CYC) + CW'(offs);
   assign prod    = PW'(per_len) * PW'(DUTY_PCT);
   assign on_cap  = CW'(prod / PW'(100));

   jit_period_timer #(
      .CW (CW)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_i),
      .len_i   (per_len),
      .start_o (per_start),
      .end_o   (per_end)
   );

   jit_pulse_gen #(
      .CW    (CW),
      .GUARD (GUARD_CYC)
   ) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_i),
      .start_i (per_start),
      .burst_i (burst_i),
      .cs_i    (cs_trip_i),
      .cap_i   (on_cap),
      .gate_o  (gate_o)
   );

   assign period_start_o = per_start;

endmodule

// File: rtl/jit_pwm_osc_chk.sv
module jit_pwm_osc_chk #(
   parameter int MIN_ON  = 4,
   parameter int CAP_MAX = 141,
   parameter int CW      = 8
) (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic burst_i,
   input logic period_start_o,
   input logic gate_o
);

   logic [CW-1:0] on_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)      on_cnt <= '0;
      else if (gate_o) on_cnt <= on_cnt + CW'(1);
      else             on_cnt <= '0;
   end

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      period_start_o |=> !period_start_o); // R4

   AST_RISE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> $past(period_start_o)); // R4

   AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      gate_o |-> (on_cnt < CW'(CAP_MAX))); // R5

   AST_MIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && $fell(gate_o)) |-> (on_cnt >= CW'(MIN_ON))); // R6

   AST_NO_PULSE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (period_start_o && burst_i) |=> !gate_o); // R9

   AST_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !gate_o); // R10

endmodule

bind jit_pwm_osc jit_pwm_osc_chk #(
   .MIN_ON  (MIN_ON_CYC),
   .CAP_MAX (ON_CAP_MAX),
   .CW      (CW)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .en_i           (en_i),
   .burst_i        (burst_i),
   .period_start_o (period_start_o),
   .gate_o         (gate_o)
);

// File: tb/tb_jit_pwm_osc.sv
`timescale 1ns/1ps
module tb_jit_pwm_osc;

   localparam int CLK_HZ = 10_000_000;
   localparam int NOM    = CLK_HZ / 60_000;
   localparam int DEV    = (CLK_HZ / 56_000 - CLK_HZ / 64_000) / 2;
   localparam int STEP   = (60_000 / 250) / (4 * DEV);
   localparam int GUARD  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_i = 1'b0;
   logic burst_i = 1'b0;
   logic cs_trip_i = 1'b0;
   logic period_start_o;
   logic gate_o;

   int n_run = 0;
   int n_fail = 0;
   int off_m = 0;
   int up_m = 1;
   int cnt_m = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   jit_pwm_osc dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .en_i           (en_i),
      .burst_i        (burst_i),
      .cs_trip_i      (cs_trip_i),
      .period_start_o (period_start_o),
      .gate_o         (gate_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   // sweep model from R3: one call per complete period
   task automatic model_adv();
      cnt_m++;
      if (cnt_m == STEP) begin
         cnt_m = 0;
         if (up_m != 0) begin
            off_m++;
            if (off_m == DEV) up_m = 0;
         end else begin
            off_m--;
            if (off_m == -DEV) up_m = 1;
         end
      end
   endtask

   // entered at the sample point of a strobe clock
   // mode 0 plain, 1 burst, 2 sense held, 3 sense pulse at clock p, 4 enable drop at clock p
   task automatic run_period(input int mode, input int p);
      int per;
      int cap;
      int len;
      int exp_len;
      bit seen_low;
      bit bad;
      int stray;
      string req;
      per = NOM + off_m;
      cap = per * 80 / 100;
      len = 0;
      seen_low = 1'b0;
      bad = 1'b0;
      stray = 0;
      burst_i = (mode == 1);
      cs_trip_i = 1'b0;
      for (int c = 1; c < per; c++) begin
         cyc();
         burst_i = 1'b0;
         cs_trip_i = (mode == 2) || (mode == 3 && c == p);
         if (mode == 4 && c == p) en_i = 1'b0;
         #1;
         if (mode == 4 && c == p) begin
            chk(gate_o == 1'b0, "R10 gate drop", int'(gate_o), 0);
            chk(period_start_o == 1'b0, "R10 strobe drop", int'(period_start_o), 0);
            for (int h = 0; h < 9; h++) begin
               cyc();
               if (gate_o || period_start_o) stray++;
            end
            chk(stray == 0, "R10 hold", stray, 0);
            en_i = 1'b1;
            #1;
            chk(period_start_o == 1'b1, "R10 restart strobe", int'(period_start_o), 1);
            return;
         end
         if (mode == 0 && c == 1) chk(gate_o == 1'b1, "R4 rise", int'(gate_o), 1);
         if (mode == 3 && c == p && p > GUARD)
            chk(gate_o == 1'b0, "R8 same clock", int'(gate_o), 0);
         if (gate_o) begin
            if (seen_low) bad = 1'b1;
            else len++;
         end else begin
            seen_low = 1'b1;
         end
         if (period_start_o) stray++;
      end
      cs_trip_i = 1'b0;
      cyc();
      chk(period_start_o == 1'b1 && stray == 0, (off_m == 0) ? "R2 period" : "R3 period",
          int'(period_start_o) - stray, 1);
      case (mode)
         1:       begin exp_len = 0;  req = "R9 burst"; end
         2:       begin exp_len = GUARD; req = "R6 held sense"; end
         3: begin
            if (p > GUARD)       begin exp_len = p - 1; req = "R8 trip"; end
            else if (p == GUARD) begin exp_len = cap; req = "R6 min on"; end
            else                 begin exp_len = cap; req = "R7 blank"; end
         end
         default: begin exp_len = cap; req = "R5 cap"; end
      endcase
      chk(len == exp_len && !bad, req, len, exp_len);
      model_adv();
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int mode;
      int p;
      for (int i = 0; i < 4; i++) begin
         cyc();
         chk(gate_o == 1'b0 && period_start_o == 1'b0, "R1 in reset",
             int'(gate_o) + int'(period_start_o), 0);
      end
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         cyc();
         chk(gate_o == 1'b0 && period_start_o == 1'b0, "R1 idle",
             int'(gate_o) + int'(period_start_o), 0);
      end
      en_i = 1'b1;
      #1;
      chk(period_start_o == 1'b1, "R10 first strobe", int'(period_start_o), 1);
      for (int i = 0; i < 262; i++) begin
         mode = 0;
         p = 0;
         case (i % 12)
            3:  mode = 1;
            5:  mode = 2;
            6:  begin mode = 3; p = 2;  end
            7:  begin mode = 3; p = 4;  end
            8:  begin mode = 3; p = 5;  end
            9:  begin mode = 3; p = 40; end
            10: begin mode = 4; p = 30; end
            default: mode = 0;
         endcase
         run_period(mode, p);
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule